// File: doc/BRIEF.md
# Mouse Drawing Packet Capture

This block listens to a receive-only PS/2 mouse link and turns its three-byte movement reports into an absolute cursor position. The position is clamped to a screen size given on input ports. Each report that arrives intact with the left button held places one drawing packet into an internal FIFO. The packet carries the updated cursor coordinates and a colour code sampled from an input port.

The FIFO is written at any time, whatever the consumer is doing. A downstream consumer, such as a video memory updater, owns the read pointer. It drives that pointer in, reads the entry the pointer selects, and compares the pointer with the exported write pointer. The empty and full flags come from the same comparison. For debugging, the block also brings out the last three received bytes, their parity status and a sticky overflow flag.

Top module: `ps2_draw_capture`

## Requirements
- R1: A PS/2 frame is 11 bits, sampled on falling edges of the synchronised and filtered PS/2 clock: a start bit of 0, eight data bits LSB first, an odd parity bit and a stop bit of 1. Within a report, the first, second and third bytes appear on `byte0_o`, `byte1_o` and `byte2_o`.
- R2: Bit i of `par_ok_o` is 1 when byte i of the latest report had odd parity over its data and parity bits, and 0 otherwise. All three bits are 0 after reset.
- R3: A report is valid only when all three bytes pass parity, every frame has start bit 0 and stop bit 1, and bit 3 of byte 0 is 1. An invalid report changes neither the cursor nor the FIFO.
- R4: A valid report whose byte-0 bit 0 (left button) is 0 updates the cursor and writes nothing to the FIFO.
- R5: On a valid report, X moves by the signed 9-bit delta {byte0 bit 4, byte1}. The result saturates at 0 and at `res_h_i` minus 1.
- R6: On a valid report, Y moves by minus the signed 9-bit delta {byte0 bit 5, byte2}. The result saturates at 0 and at `res_v_i` minus 1.
- R7: A FIFO word holds the colour in bits [22:20], X in bits [19:10] and Y in bits [9:0]. The coordinates are those after the report has been applied.
- R8: `empty_o` is high exactly when `wr_addr_o` equals `rd_addr_i`. `full_o` is high exactly when `wr_addr_o` plus 1, modulo the depth, equals `rd_addr_i`. `wr_addr_o` advances by one for each stored packet.
- R9: A packet arriving while the FIFO is full is dropped and `wr_addr_o` does not move. `overflow_o` is set and stays set until reset.
- R10: If no PS/2 clock falling edge arrives for `TIMEOUT_CYC` cycles, the next byte received is taken as byte 0 of a new report.
- R11: After reset, the cursor is at (0,0), `wr_addr_o` is 0 and `overflow_o` is 0.
- R12: `rd_data_o` shows the FIFO entry at `rd_addr_i` one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | PS/2 clock line (receive only) |
| ps2_data_i | input | 1 | PS/2 data line (receive only) |
| color_i | input | 3 | Colour code packed into each packet |
| res_h_i | input | 10 | Horizontal resolution |
| res_v_i | input | 10 | Vertical resolution |
| rd_addr_i | input | AW | Read pointer driven by the consumer |
| rd_data_o | output | 23 | FIFO word at the read pointer (registered) |
| wr_addr_o | output | AW | Write pointer |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| overflow_o | output | 1 | Sticky packet-dropped flag |
| cursor_x_o | output | 10 | Cursor X |
| cursor_y_o | output | 10 | Cursor Y |
| par_ok_o | output | 3 | Parity status per report byte |
| byte0_o | output | 8 | Last report byte 0 |
| byte1_o | output | 8 | Last report byte 1 |
| byte2_o | output | 8 | Last report byte 2 |

## Verification
The bench sweeps positive, negative, small and full-range 9-bit deltas against a 40 by 30 screen. This exercises plain movement apart from saturation at both edges of each axis. Reports with and without the left button separate cursor update from packet capture. A corrupted parity bit, a bad stop bit and a cleared byte-0 bit 3 each have to leave the cursor and the FIFO untouched. The FIFO is filled to full and pushed once more, then drained, which covers the pointer wrap and overflow. A stray single byte followed by a long gap shows that the idle timeout realigns the report.

// File: rtl/ps2_draw_pkg.sv
package ps2_draw_pkg;
  localparam int CW    = 10;
  localparam int COL_W = 3;
  localparam int PKT_W = COL_W + 2 * CW;

  typedef struct packed {
    logic [COL_W-1:0] color;
    logic [CW-1:0]    x;
    logic [CW-1:0]    y;
  } pkt_t;
endpackage

// File: rtl/ps2_rx.sv
module ps2_rx #(
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       par_ok_o,
  output logic       frame_ok_o,
  output logic       tmo_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [1:0]          clk_s, dat_s;
  logic [FILT_LEN-1:0] flt_q;
  logic                clk_f_q, clk_f_d, fall;
  logic [3:0]          bit_q;
  logic [9:0]          sh_q;
  logic [TW-1:0]       idle_q;

  always_comb begin
    clk_f_d = clk_f_q;
    if (&flt_q)       clk_f_d = 1'b1;
    else if (~|flt_q) clk_f_d = 1'b0;
  end
  assign fall = clk_f_q & ~clk_f_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_s      <= '1;
      dat_s      <= '1;
      flt_q      <= '1;
      clk_f_q    <= 1'b1;
      bit_q      <= '0;
      sh_q       <= '0;
      idle_q     <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      par_ok_o   <= 1'b0;
      frame_ok_o <= 1'b0;
      tmo_o      <= 1'b0;
    end else begin
      clk_s      <= {clk_s[0], ps2_clk_i};
      dat_s      <= {dat_s[0], ps2_data_i};
      flt_q      <= {flt_q[FILT_LEN-2:0], clk_s[1]};
      clk_f_q    <= clk_f_d;
      byte_vld_o <= 1'b0;
      tmo_o      <= 1'b0;
      if (fall) begin
        idle_q <= '0;
        if (bit_q == 4'd10) begin
          // sh_q: [0] start, [8:1] data, [9] parity; current bit is stop
          bit_q      <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= sh_q[8:1];
          par_ok_o   <= ^sh_q[9:1];
          frame_ok_o <= dat_s[1] & ~sh_q[0];
        end else begin
          bit_q <= bit_q + 4'd1;
          sh_q  <= {dat_s[1], sh_q[9:1]};
        end
      end else if (idle_q != TW'(TIMEOUT_CYC)) begin
        idle_q <= idle_q + TW'(1);
        if (idle_q == TW'(TIMEOUT_CYC - 1)) begin
          tmo_o <= 1'b1;
          bit_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/report_asm.sv
module report_asm (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  input  logic            par_ok_i,
  input  logic            frame_ok_i,
  input  logic            tmo_i,
  output logic [2:0][7:0] bytes_o,
  output logic [2:0]      par_o,
  output logic            rpt_ok_o
);
  logic [1:0] idx_q;
  logic [2:0] fok_q;
  logic       done_q;

  for (genvar g = 0; g < 3; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bytes_o[g] <= '0;
        par_o[g]   <= 1'b0;
        fok_q[g]   <= 1'b0;
      end else if (byte_vld_i && idx_q == 2'(g)) begin
        bytes_o[g] <= byte_i;
        par_o[g]   <= par_ok_i;
        fok_q[g]   <= frame_ok_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tmo_i) begin
        idx_q <= '0;
      end else if (byte_vld_i) begin
        if (idx_q == 2'd2) begin
          idx_q  <= '0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  // byte 0 bit 3 is the always-one marker
  assign rpt_ok_o = done_q & (&par_o) & (&fok_q) & bytes_o[0][3];
endmodule

// File: rtl/cursor_track.sv
module cursor_track #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          dx_s_i,
  input  logic [7:0]    dx_i,
  input  logic          dy_s_i,
  input  logic [7:0]    dy_i,
  input  logic [CW-1:0] res_h_i,
  input  logic [CW-1:0] res_v_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic [CW-1:0] nx_o,
  output logic [CW-1:0] ny_o
);
  localparam int SW = CW + 2;

  logic signed [SW-1:0] dx, dy, sx, sy;

  function automatic logic [CW-1:0] sat(logic signed [SW-1:0] v, logic [CW-1:0] res);
    if (v < 0) return '0;
    if (v >= $signed({2'b00, res})) return (res == '0) ? '0 : res - 1'b1;
    return v[CW-1:0];
  endfunction

  assign dx   = {{(SW-9){dx_s_i}}, dx_s_i, dx_i};
  assign dy   = {{(SW-9){dy_s_i}}, dy_s_i, dy_i};
  assign sx   = $signed({2'b00, x_o}) + dx;
  assign sy   = $signed({2'b00, y_o}) - dy;  // screen Y grows downward
  assign nx_o = sat(sx, res_h_i);
  assign ny_o = sat(sy, res_v_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else if (upd_i) begin
      x_o <= nx_o;
      y_o <= ny_o;
    end
  end
endmodule

// File: rtl/draw_fifo.sv
module draw_fifo #(
  parameter int AW = 9,
  parameter int W  = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  assign empty_o = (wr_addr_o == rd_addr_i);
  assign full_o  = ((wr_addr_o + AW'(1)) == rd_addr_i);

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_addr_o] <= din_i;
    rd_data_o <= mem_q[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_o <= '0;
      ovf_o     <= 1'b0;
    end else if (push_i) begin
      if (full_o) ovf_o     <= 1'b1;
      else        wr_addr_o <= wr_addr_o + AW'(1);
    end
  end
endmodule

// File: rtl/ps2_draw_capture.sv
module ps2_draw_capture
  import ps2_draw_pkg::*;
#(
  parameter int AW          = 9,
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ps2_clk_i,
  input  logic             ps2_data_i,
  input  logic [COL_W-1:0] color_i,
  input  logic [CW-1:0]    res_h_i,
  input  logic [CW-1:0]    res_v_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [PKT_W-1:0] rd_data_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             overflow_o,
  output logic [CW-1:0]    cursor_x_o,
  output logic [CW-1:0]    cursor_y_o,
  output logic [2:0]       par_ok_o,
  output logic [7:0]       byte0_o,
  output logic [7:0]       byte1_o,
  output logic [7:0]       byte2_o
);
  logic            byte_vld, byte_par, byte_fok, tmo;
  logic [7:0]      rx_byte;
  logic [2:0][7:0] rpt_bytes;
  logic            rpt_ok, push;
  logic [CW-1:0]   nx, ny;
  pkt_t            pkt;

  ps2_rx #(.FILT_LEN(FILT_LEN), .TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk_i, .rst_ni, .ps2_clk_i, .ps2_data_i,
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .par_ok_o(byte_par),
    .frame_ok_o(byte_fok), .tmo_o(tmo)
  );

  report_asm u_asm (
    .clk_i, .rst_ni, .byte_vld_i(byte_vld), .byte_i(rx_byte),
    .par_ok_i(byte_par), .frame_ok_i(byte_fok), .tmo_i(tmo),
    .bytes_o(rpt_bytes), .par_o(par_ok_o), .rpt_ok_o(rpt_ok)
  );

  cursor_track #(.CW(CW)) u_cur (
    .clk_i, .rst_ni, .upd_i(rpt_ok),
    .dx_s_i(rpt_bytes[0][4]), .dx_i(rpt_bytes[1]),
    .dy_s_i(rpt_bytes[0][5]), .dy_i(rpt_bytes[2]),
    .res_h_i, .res_v_i,
    .x_o(cursor_x_o), .y_o(cursor_y_o), .nx_o(nx), .ny_o(ny)
  );

  assign push = rpt_ok & rpt_bytes[0][0];
  assign pkt  = '{color: color_i, x: nx, y: ny};

  draw_fifo #(.AW(AW), .W(PKT_W)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(pkt), .rd_addr_i,
    .rd_data_o, .wr_addr_o, .empty_o, .full_o, .ovf_o(overflow_o)
  );

  assign byte0_o = rpt_bytes[0];
  assign byte1_o = rpt_bytes[1];
  assign byte2_o = rpt_bytes[2];
endmodule

// File: rtl/ps2_draw_capture_chk.sv
module ps2_draw_capture_chk #(
  parameter int AW = 9,
  parameter int CW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          empty_i,
  input logic          full_i,
  input logic          ovf_i,
  input logic          push_i,
  input logic          rpt_ok_i,
  input logic [AW-1:0] wr_i,
  input logic [CW-1:0] x_i,
  input logic [CW-1:0] y_i,
  input logic [CW-1:0] rh_i,
  input logic [CW-1:0] rv_i
);
  // R8
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_i && full_i));
  // R8
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i != $past(wr_i)) |-> (wr_i == $past(wr_i) + AW'(1)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);
  // R9
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_i) |=> ($stable(wr_i) && ovf_i));
  // R5
  x_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ok_i && rh_i != '0 && $stable(rh_i)) |=> (x_i < rh_i));
  // R6
  y_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ok_i && rv_i != '0 && $stable(rv_i)) |=> (y_i < rv_i));
endmodule

bind ps2_draw_capture ps2_draw_capture_chk #(.AW(AW), .CW(ps2_draw_pkg::CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .empty_i(empty_o), .full_i(full_o),
  .ovf_i(overflow_o), .push_i(push), .rpt_ok_i(rpt_ok), .wr_i(wr_addr_o),
  .x_i(cursor_x_o), .y_i(cursor_y_o), .rh_i(res_h_i), .rv_i(res_v_i)
);

// File: tb/tb_ps2_draw_capture.sv
module tb_ps2_draw_capture;
  localparam int AW = 3, DEPTH = 8, TMO = 2000, RH = 40, RV = 30;

  logic clk = 0, rst_n = 0, ps2c = 1, ps2d = 1;
  logic [2:0]    color = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [22:0]   rd_data;
  logic [AW-1:0] wr_addr;
  logic          empty, full, ovf;
  logic [9:0]    cx, cy;
  logic [2:0]    par;
  logic [7:0]    b0o, b1o, b2o;

  ps2_draw_capture #(.AW(AW), .FILT_LEN(4), .TIMEOUT_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(ps2c), .ps2_data_i(ps2d),
    .color_i(color), .res_h_i(10'(RH)), .res_v_i(10'(RV)), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .wr_addr_o(wr_addr), .empty_o(empty), .full_o(full),
    .overflow_o(ovf), .cursor_x_o(cx), .cursor_y_o(cy), .par_ok_o(par),
    .byte0_o(b0o), .byte1_o(b1o), .byte2_o(b2o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int ex_x = 0, ex_y = 0, ex_wr = 0, ex_rd = 0;
  bit ex_ovf = 0;
  logic [22:0] ex_q [DEPTH];

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int clampf(int v, int res);
    if (v < 0) return 0;
    if (v >= res) return res - 1;
    return v;
  endfunction

  function automatic bit mfull();
    return ((ex_wr + 1) % DEPTH) == ex_rd;
  endfunction

  task automatic send_byte(logic [7:0] b, bit flip, bit stopv);
    logic [10:0] f;
    f = {stopv, (~^b) ^ flip, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      ps2d = f[i]; cyc(10);
      ps2c = 0;    cyc(20);
      ps2c = 1;    cyc(10);
    end
    ps2d = 1;
    cyc(100);
  endtask

  task automatic flags_chk();
    chk(empty == (ex_wr == ex_rd), "R8 empty", empty, ex_wr == ex_rd);
    chk(full == mfull(), "R8 full", full, mfull());
  endtask

  task automatic report(int dx, int dy, bit left, int col,
                        bit badp = 0, bit bads = 0, bit nob3 = 0);
    logic [7:0] b0, b1, b2;
    bit valid;
    b0 = {2'b00, dy < 0, dx < 0, ~nob3, 2'b00, left};
    b1 = dx[7:0];
    b2 = dy[7:0];
    color = col[2:0];
    send_byte(b0, 0, 1);
    send_byte(b1, badp, 1);
    send_byte(b2, 0, ~bads);
    cyc(20);
    valid = !badp && !bads && !nob3;
    if (valid) begin
      ex_x = clampf(ex_x + dx, RH);
      ex_y = clampf(ex_y - dy, RV);
      if (left) begin
        if (mfull()) ex_ovf = 1;
        else begin
          ex_q[ex_wr] = {col[2:0], ex_x[9:0], ex_y[9:0]};
          ex_wr = (ex_wr + 1) % DEPTH;
        end
      end
    end
    chk(cx == ex_x, valid ? "R5 x" : "R3 x kept", cx, ex_x);
    chk(cy == ex_y, valid ? "R6 y" : "R3 y kept", cy, ex_y);
    chk({b0o, b1o, b2o} == {b0, b1, b2}, "R1 bytes", {b0o, b1o, b2o}, {b0, b1, b2});
    chk(par == {1'b1, ~badp, 1'b1}, "R2 parity", par, {1'b1, ~badp, 1'b1});
    chk(wr_addr == ex_wr, left ? "R3 wr" : "R4 wr", wr_addr, ex_wr);
    chk(ovf == ex_ovf, "R9 ovf", ovf, ex_ovf);
    flags_chk();
  endtask

  task automatic pop();
    rd_addr = ex_rd[AW-1:0];
    cyc(2);
    chk(rd_data == ex_q[ex_rd], "R7 R12 data", rd_data, ex_q[ex_rd]);
    ex_rd = (ex_rd + 1) % DEPTH;
    rd_addr = ex_rd[AW-1:0];
    cyc(1);
    flags_chk();
  endtask

  task automatic reset_chk();
    chk(cx == 0 && cy == 0, "R11 cursor", {cx, cy}, 0);
    chk(wr_addr == 0, "R11 wr", wr_addr, 0);
    chk(ovf == 0, "R11 ovf", ovf, 0);
    chk(par == 0, "R2 reset", par, 0);
    flags_chk();
  endtask

  initial begin
    cyc(3);
    reset_chk();
    rst_n = 1;
    cyc(5);
    // R4: no button; R6 saturates at top edge
    report(5, 3, 0, 1);
    // sweep deltas; pop after each so the FIFO stays shallow
    for (int i = 0; i < 10; i++) begin
      int dx, dy;
      dx = (i % 2 == 0) ? (i * 7 - 20) : (((i * 97) % 512) - 256);
      dy = (i % 3 == 0) ? (11 - i * 3) : (((i * 61) % 512) - 256);
      report(dx, dy, (i != 3 && i != 7), i % 8);
      if (ex_wr != ex_rd) pop();
    end
    // full boundary then one extra push: R8, R9
    while (!mfull()) report(1, -1, 1, 6);
    chk(full == 1, "R8 at full", full, 1);
    report(2, 2, 1, 7);
    chk(wr_addr == ex_wr, "R9 drop", wr_addr, ex_wr);
    while (ex_wr != ex_rd) pop();
    // invalid reports: R3, overflow stays set
    report(7, -4, 1, 2, 1, 0, 0);
    report(7, -4, 1, 2, 0, 1, 0);
    report(7, -4, 1, 2, 0, 0, 1);
    // R10: stray byte then long silence realigns
    send_byte(8'h09, 0, 1);
    cyc(TMO + 500);
    report(3, 2, 1, 5);
    chk(wr_addr == ex_wr, "R10 resync", wr_addr, ex_wr);
    pop();
    // R11: reset clears sticky overflow and pointers
    rst_n = 0;
    rd_addr = '0;
    ex_x = 0; ex_y = 0; ex_wr = 0; ex_rd = 0; ex_ovf = 0;
    cyc(3);
    reset_chk();
    rst_n = 1;
    cyc(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule